// File: doc/BRIEF.md
# Condition-Field Mask/Mode Compare Unit

The unit runs a small family of condition-field operations. Each operation takes a 4-bit source, tests each bit for equality with a 4-bit mode pattern, and gates the outcome with a 4-bit mask. The 4-bit result goes either to one of eight 4-bit condition fields, which the unit holds itself, or to a 64-bit general-purpose register. The general-purpose register file sits outside the unit and is reached through one read port and one write port.

A merge flag selects between two ways of writing the destination. With the flag clear, the destination is overwritten. With the flag set, the destination is read, modified and written back, so that the bits outside the mask keep their old value. One decoded operation is accepted per cycle under a valid strobe. Condition-field writes land on the next clock edge. The general-purpose write request is presented in the same cycle, so that the external file commits it on that same edge.

Top module: `cfm_unit`

## Requirements
- R1: `imm_i[7:4]` is the mask and `imm_i[3:0]` is the mode. Result bit i is mask[i] AND (mode[i] == src[i]). Field bit 0 is the most significant bit of each nibble, and mask and mode use the same order.
- R2: Variant 2'b00 compares condition field `src_field_i` and writes register `gpr_sel_i`. In the same cycle, `gpr_we_o` is high, `gpr_waddr_o` equals `gpr_sel_i`, and `gpr_wdata_o[3:0]` holds the result with field bit 0 at bit 3. Bits 63:4 are zero.
- R3: Variant 2'b01 takes bit 0 (the least significant bit) of register `gpr_sel_i` and compares it at all four positions. The result is written to field `dst_field_i`. A selector of 0 supplies zero, whatever the read data is, and `gpr_re_o` stays low.
- R4: Variant 2'b11 compares field `src_field_i` and writes field `dst_field_i`. The new value appears on `cr_o` after the next rising edge.
- R5: With `merge_i`=1, each destination bit outside the mask keeps its previous value. For variant 2'b00 that previous value is the low nibble of the destination register, read through the read port (`gpr_re_o` high).
- R6: With `merge_i`=0, each destination bit outside the mask is written as zero. Variant 2'b00 does not read the destination register (`gpr_re_o` low).
- R7: Variant 2'b10 is reserved. It writes neither a condition field nor a register.
- R8: While `valid_i` is low, `gpr_we_o` and `gpr_re_o` are low and `cr_o` holds its value.
- R9: After reset all eight fields are zero. Field k sits at `cr_o[31-4k -: 4]`.
- R10: Three idioms work on field `dst_field_i`:
  - Set: variant 2'b01 with selector 0, merge 1 and mode 0000 sets the masked bits.
  - Clear: the same with mode 1111 clears the masked bits.
  - Load: selector 0, merge 0, mask 1111 and mode ~p loads pattern p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation valid strobe |
| variant_i | input | 2 | Variant select (00, 01, 11; 10 reserved) |
| merge_i | input | 1 | Keep bits outside the mask |
| imm_i | input | 8 | Mask (upper nibble) and mode (lower nibble) |
| src_field_i | input | 3 | Source condition field |
| dst_field_i | input | 3 | Destination condition field |
| gpr_sel_i | input | 5 | General-purpose register selector |
| gpr_rdata_i | input | 64 | Read data for `gpr_raddr_o` |
| gpr_re_o | output | 1 | Register read in use |
| gpr_raddr_o | output | 5 | Register read address |
| gpr_we_o | output | 1 | Register write enable |
| gpr_waddr_o | output | 5 | Register write address |
| gpr_wdata_o | output | 64 | Register write data |
| cr_o | output | 32 | All eight condition fields |

## Verification
The read enable, write enable, write address and write data on the register port are combinational in the operation inputs. They are therefore checked 1 ns after the inputs change, in the same cycle. Condition-field results exist only after the next rising edge, so `cr_o` is compared 1 ns after that edge. Also at that edge, the bench's own model of the register file absorbs the write it saw before the edge.

Every combination of variant, merge flag and 8-bit immediate is run against that model. Source, destination and register selectors are rotated across the run, and register 0 holds a nonzero value so that the zero-selector rule is observable.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  typedef enum logic [1:0] {
    VAR_CR2GPR = 2'b00,
    VAR_GPR2CR = 2'b01,
    VAR_RSVD   = 2'b10,
    VAR_CR2CR  = 2'b11
  } cfm_var_e;
endpackage

// File: rtl/cfm_eval.sv
module cfm_eval #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] mask_i,
  input  logic [FW-1:0] mode_i,
  input  logic [FW-1:0] src_i,
  input  logic [FW-1:0] old_i,
  input  logic          merge_i,
  output logic [FW-1:0] res_o
);
  for (genvar b = 0; b < FW; b++) begin : g_bit
    logic hit;
    assign hit      = mask_i[b] & (mode_i[b] == src_i[b]);
    assign res_o[b] = hit | (merge_i & ~mask_i[b] & old_i[b]);
  end
endmodule

// File: rtl/cfm_crfile.sv
module cfm_crfile #(
  parameter int NF = 8,
  parameter int FW = 4,
  localparam int AW = $clog2(NF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [FW-1:0] wdata_i,
  output logic [NF*FW-1:0] flat_o
);
  // field 0 in the top nibble
  for (genvar k = 0; k < NF; k++) begin : g_field
    logic [FW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (we_i && waddr_i == AW'(k))    q <= wdata_i;
    end
    assign flat_o[(NF-1-k)*FW +: FW] = q;
  end

  AST_CR_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flat_o)); // R8
endmodule

// File: rtl/cfm_unit.sv
module cfm_unit
  import cfm_pkg::*;
#(
  parameter int NF   = 8,
  parameter int FW   = 4,
  parameter int XLEN = 64,
  parameter int GAW  = 5,
  localparam int FAW = $clog2(NF),
  localparam int CRW = NF*FW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      variant_i,
  input  logic            merge_i,
  input  logic [2*FW-1:0] imm_i,
  input  logic [FAW-1:0]  src_field_i,
  input  logic [FAW-1:0]  dst_field_i,
  input  logic [GAW-1:0]  gpr_sel_i,
  input  logic [XLEN-1:0] gpr_rdata_i,
  output logic            gpr_re_o,
  output logic [GAW-1:0]  gpr_raddr_o,
  output logic            gpr_we_o,
  output logic [GAW-1:0]  gpr_waddr_o,
  output logic [XLEN-1:0] gpr_wdata_o,
  output logic [CRW-1:0]  cr_o
);
  cfm_var_e      var_s;
  logic [FW-1:0] mask, mode, src, old, res;
  logic [FW-1:0] cr_src, cr_dst;
  logic          gpr_bit, gpr_src, cr_we;
  logic [CRW-1:0] cr_flat;
  logic          unused_rdata;

  function automatic logic [FW-1:0] field_of(logic [CRW-1:0] f, logic [FAW-1:0] idx);
    logic [FW-1:0] r;
    r = '0;
    for (int k = 0; k < NF; k++)
      if (idx == FAW'(k)) r = f[(NF-1-k)*FW +: FW];
    return r;
  endfunction

  assign var_s   = cfm_var_e'(variant_i);
  assign mask    = imm_i[2*FW-1:FW];
  assign mode    = imm_i[FW-1:0];
  assign cr_src  = field_of(cr_flat, src_field_i);
  assign cr_dst  = field_of(cr_flat, dst_field_i);
  assign gpr_src = (var_s == VAR_GPR2CR);
  // selector 0 reads as zero
  assign gpr_bit = (gpr_sel_i != '0) & gpr_rdata_i[0];
  assign src     = gpr_src ? {FW{gpr_bit}} : cr_src;

  always_comb begin
    old = '0;
    if (merge_i) old = (var_s == VAR_CR2GPR) ? gpr_rdata_i[FW-1:0] : cr_dst;
  end

  cfm_eval #(.FW(FW)) u_eval (
    .mask_i(mask), .mode_i(mode), .src_i(src), .old_i(old),
    .merge_i(merge_i), .res_o(res)
  );

  assign gpr_raddr_o = gpr_sel_i;
  assign gpr_re_o    = valid_i & ((gpr_src & (gpr_sel_i != '0)) |
                                  ((var_s == VAR_CR2GPR) & merge_i));
  assign gpr_we_o    = valid_i & (var_s == VAR_CR2GPR);
  assign gpr_waddr_o = gpr_sel_i;
  assign gpr_wdata_o = {{(XLEN-FW){1'b0}}, res};
  assign cr_we       = valid_i & ((var_s == VAR_GPR2CR) | (var_s == VAR_CR2CR));
  assign unused_rdata = ^gpr_rdata_i[XLEN-1:FW];

  cfm_crfile #(.NF(NF), .FW(FW)) u_crfile (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cr_we),
    .waddr_i(dst_field_i), .wdata_i(res), .flat_o(cr_flat)
  );
  assign cr_o = cr_flat;

  AST_GPR_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o |-> gpr_wdata_o[XLEN-1:FW] == '0); // R2
  AST_IDLE_NO_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !gpr_we_o && !gpr_re_o); // R8
  AST_RSVD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && variant_i == 2'b10 |-> !gpr_we_o ##1 $stable(cr_o)); // R7
  AST_GPR_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o && !merge_i |-> (gpr_wdata_o[FW-1:0] & ~imm_i[2*FW-1:FW]) == '0 && !gpr_re_o); // R6
  AST_CR_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && variant_i[0] && !merge_i |=>
      (field_of(cr_o, $past(dst_field_i)) & ~$past(imm_i[2*FW-1:FW])) == '0); // R6
  AST_CR_MERGE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && variant_i[0] && merge_i |=>
      ((field_of(cr_o, $past(dst_field_i)) ^ field_of($past(cr_o), $past(dst_field_i)))
        & ~$past(imm_i[2*FW-1:FW])) == '0); // R5
endmodule

// File: tb/cfm_unit_bench.sv
module cfm_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  variant = 2'b00;
  logic        merge = 1'b0;
  logic [7:0]  imm = '0;
  logic [2:0]  sf = '0, df = '0;
  logic [4:0]  gs = '0;
  logic [63:0] rdata;
  logic        re, we;
  logic [4:0]  raddr, waddr;
  logic [63:0] wdata;
  logic [31:0] cr;

  logic [63:0] gprs [32];
  logic [3:0]  crf  [8];
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;
  assign rdata = gprs[raddr];

  cfm_unit u_cfm_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .variant_i(variant),
    .merge_i(merge), .imm_i(imm), .src_field_i(sf), .dst_field_i(df),
    .gpr_sel_i(gs), .gpr_rdata_i(rdata), .gpr_re_o(re), .gpr_raddr_o(raddr),
    .gpr_we_o(we), .gpr_waddr_o(waddr), .gpr_wdata_o(wdata), .cr_o(cr)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cr_pack();
    logic [31:0] p;
    for (int k = 0; k < 8; k++) p[31-4*k -: 4] = crf[k];
    return p;
  endfunction

  task automatic op(input logic v, input logic [1:0] vr, input logic m,
                    input logic [7:0] im, input logic [2:0] s, input logic [2:0] d,
                    input logic [4:0] g, input string req);
    logic [3:0] msk, mde, src, old, res;
    logic       lsb, exp_re, exp_we, exp_cr;
    logic [63:0] cap;
    @(negedge clk);
    valid = v; variant = vr; merge = m; imm = im; sf = s; df = d; gs = g;
    #1;
    msk = im[7:4]; mde = im[3:0];
    lsb = (g == 0) ? 1'b0 : gprs[g][0];
    src = (vr == 2'b01) ? {4{lsb}} : crf[s];
    old = 4'h0;
    if (m) old = (vr == 2'b00) ? gprs[g][3:0] : crf[d];
    // MSB0: field bit i is vector bit 3-i
    for (int i = 0; i < 4; i++)
      res[3-i] = (msk[3-i] && (mde[3-i] == src[3-i])) || (m && !msk[3-i] && old[3-i]);
    exp_we = v && vr == 2'b00;
    exp_re = v && ((vr == 2'b01 && g != 0) || (vr == 2'b00 && m));
    exp_cr = v && (vr == 2'b01 || vr == 2'b11);
    chk({req, " re"}, 64'(re), 64'(exp_re));
    chk({req, " we"}, 64'(we), 64'(exp_we));
    cap = wdata;
    if (exp_we) begin
      chk({req, " waddr"}, 64'(waddr), 64'(g));
      chk({req, " wdata"}, cap, {60'h0, res});
    end
    @(posedge clk);
    #1;
    if (exp_we) gprs[g] = cap;
    if (exp_cr) crf[d] = res;
    chk({req, " cr"}, 64'(cr), 64'(cr_pack()));
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) gprs[i] = (64'(i) + 64'd7) * 64'h9E3779B97F4A7C15;
    gprs[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int k = 0; k < 8; k++) crf[k] = 4'h0;
    #(3*CLK_P);
    chk("R9 reset", 64'(cr), 64'h0);
    rst_n = 1'b1;

    // R10 idioms on field 2
    op(1, 2'b01, 0, 8'hF5, 0, 2, 0, "R10 load");
    chk("R10 load value", 64'(cr[31-8 -: 4]), 64'hA);
    op(1, 2'b01, 1, 8'h50, 0, 2, 0, "R10 set");
    chk("R10 set value", 64'(cr[31-8 -: 4]), 64'hF);
    op(1, 2'b01, 1, 8'hCF, 0, 2, 0, "R10 clear");
    chk("R10 clear value", 64'(cr[31-8 -: 4]), 64'h3);

    // R3: selector 0 reads zero even though register 0 is all ones
    op(1, 2'b01, 0, 8'hF0, 0, 5, 0, "R3 sel0");
    chk("R3 sel0 value", 64'(cr[31-20 -: 4]), 64'hF);

    // fill fields with distinct patterns (R4 source data)
    for (int k = 0; k < 8; k++)
      op(1, 2'b01, 0, {4'hF, ~4'(k*5+3)}, 0, 3'(k), 0, "R9 fill");

    // R8: valid low
    for (int n = 0; n < 8; n++)
      op(0, 2'(n), n[0], 8'(n*37), 3'(n), 3'(n+1), 5'(n), "R8 idle");

    // exhaustive: R1 R2 R3 R4 R5 R6 R7
    for (int vr = 0; vr < 4; vr++)
      for (int m = 0; m < 2; m++)
        for (int im = 0; im < 256; im++) begin
          int t;
          t = vr*512 + m*256 + im;
          op(1, 2'(vr), 1'(m), 8'(im), 3'(t), 3'(t*3+1), 5'(t*7),
             vr == 2 ? "R7 rsvd" : (m ? "R5 merge R1" : "R6 overwrite R2 R3 R4"));
        end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule